// File: doc/BRIEF.md
# Interface Identifier Translation Unit

This unit turns an interface identifier chosen by software into a short hardware logical-unit number. Software passes an operand whose low 12 bits name a device sequence number and whose upper bits name an interface. It also supplies a second operand carrying payload data, a variant select that chooses the value returned on a miss, and the current one-hot privilege level. The unit searches a small associative table. Each entry in the table holds an identifier, a device number, a required privilege code and a 12-bit logical unit.

On a hit, the 12-bit unit is packed beneath the low bits of the payload operand. The result can then be used directly as the first operand of a later command instruction. On a miss, the result is a small fallback unit number, and that number depends on the variant. A later command stage can then either trap or return a constant. The table is filled at boot time through an indexed write port, and a single clear input invalidates every entry. The result is registered and appears together with a one-cycle done pulse on the clock edge after the request.

The identifier field is XLEN-12 bits wide, so XLEN should be at least 32 to give an identifier of at least 20 bits.

Top module: `ifid_xlate`

## Requirements
- R1: The request operand is split so that bits 11:0 form the device number and bits XLEN-1:12 form the interface identifier; a device number of 0 is an ordinary key value that selects the default implementation.
- R2: On a hit, result bits 11:0 equal the matching entry's logical unit and result bits XLEN-1:12 equal payload bits XLEN-13:0.
- R3: An entry matches only when it is valid and its identifier, its device number and its privilege code all equal the request's; a differing privilege gives a miss.
- R4: On a miss, the result is 0 for variant 0 (trap), 1 for variant 1 (return zero), 2 for variant 2 (return all ones) and 0 for variant 3, with bits XLEN-1:12 all zero.
- R5: Privilege codes are one-hot (user 4'b0001, supervisor 4'b0010, hypervisor 4'b0100, machine 4'b1000), and one identifier/device pair may map to different units at different privilege levels.
- R6: When several entries match, the entry with the lowest index supplies the unit.
- R7: A write with an in-range index loads that entry's fields and marks it valid. Requests accepted on the following edge or later see the new contents.
- R8: The clear input invalidates all entries on the next edge, and it takes precedence over a write in the same cycle.
- R9: The done output is high in exactly the cycle after each request strobe. The result register changes only on an edge where a request is accepted, and it holds its value otherwise.
- R10: After reset, done is 0, the result is 0 and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_clear | input | 1 | Invalidate all table entries |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W | Entry index to write |
| tbl_wr_ident | input | XLEN-12 | Interface identifier for the entry |
| tbl_wr_dev | input | 12 | Device number for the entry |
| tbl_wr_priv | input | 4 | Required one-hot privilege code for the entry |
| tbl_wr_unit | input | 12 | Logical unit stored in the entry |
| req_valid | input | 1 | Request strobe |
| req_variant | input | 2 | Miss behaviour: 0 trap, 1 zero, 2 all ones |
| req_priv | input | 4 | Current one-hot privilege level |
| req_rs1 | input | XLEN | Identifier and device number operand |
| req_data | input | XLEN-12 | Low bits of the payload operand |
| rsp_done | output | 1 | One-cycle pulse marking a new result |
| rsp_rd | output | XLEN | Packed unit and payload, or the fallback unit |

## Verification
A result is due one clock edge after its request strobe. The bench raises the strobe at a falling edge, and it reads rsp_done and rsp_rd at the next falling edge. That sampling point is half a cycle after the capturing edge. Table writes and clears take effect on their own edge, so each request that depends on them is issued at least one cycle after the write or clear. The bench also reads the outputs one further cycle after the request, to confirm that done has fallen and that the result has held.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

  localparam int UNIT_W = 12;
  localparam int DEV_W  = 12;
  localparam int PRIV_W = 4;

  typedef enum logic [1:0] {
    VAR_TRAP = 2'd0,
    VAR_ZERO = 2'd1,
    VAR_ONES = 2'd2,
    VAR_RSVD = 2'd3
  } xvariant_e;

  localparam logic [PRIV_W-1:0] PRIV_USER  = 4'b0001;
  localparam logic [PRIV_W-1:0] PRIV_SUPER = 4'b0010;
  localparam logic [PRIV_W-1:0] PRIV_HYPER = 4'b0100;
  localparam logic [PRIV_W-1:0] PRIV_MACH  = 4'b1000;

  // Fallback unit number selected by the instruction variant on a miss.
  function automatic logic [UNIT_W-1:0] miss_unit(input logic [1:0] variant);
    logic [UNIT_W-1:0] u;
    case (xvariant_e'(variant))
      VAR_ZERO: u = UNIT_W'(1);
      VAR_ONES: u = UNIT_W'(2);
      default:  u = '0;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/ifx_table.sv
module ifx_table
  import ifx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 20,
  parameter int IDX_W   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clear,
  input  logic                                 wr_en,
  input  logic [IDX_W-1:0]                     wr_idx,
  input  logic [ID_W-1:0]                      wr_ident,
  input  logic [DEV_W-1:0]                     wr_dev,
  input  logic [PRIV_W-1:0]                    wr_priv,
  input  logic [UNIT_W-1:0]                    wr_unit,
  output logic [ENTRIES-1:0]                   ent_valid,
  output logic [ENTRIES-1:0][ID_W-1:0]         ent_ident,
  output logic [ENTRIES-1:0][DEV_W-1:0]        ent_dev,
  output logic [ENTRIES-1:0][PRIV_W-1:0]       ent_priv,
  output logic [ENTRIES-1:0][UNIT_W-1:0]       ent_unit
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              sel;
    logic              valid_d, valid_q;
    logic [ID_W-1:0]   ident_q;
    logic [DEV_W-1:0]  dev_q;
    logic [PRIV_W-1:0] priv_q;
    logic [UNIT_W-1:0] unit_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    // Clear dominates a write in the same cycle.
    always_comb begin
      valid_d = valid_q;
      if (clear)    valid_d = 1'b0;
      else if (sel) valid_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= valid_d;
    end

    // Payload fields carry no reset; they are qualified by valid_q.
    always_ff @(posedge clk) begin
      if (sel) begin
        ident_q <= wr_ident;
        dev_q   <= wr_dev;
        priv_q  <= wr_priv;
        unit_q  <= wr_unit;
      end
    end

    assign ent_valid[g] = valid_q;
    assign ent_ident[g] = ident_q;
    assign ent_dev[g]   = dev_q;
    assign ent_priv[g]  = priv_q;
    assign ent_unit[g]  = unit_q;
  end

endmodule

// File: rtl/ifx_match.sv
module ifx_match
  import ifx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 20
) (
  input  logic [ENTRIES-1:0]                   ent_valid,
  input  logic [ENTRIES-1:0][ID_W-1:0]         ent_ident,
  input  logic [ENTRIES-1:0][DEV_W-1:0]        ent_dev,
  input  logic [ENTRIES-1:0][PRIV_W-1:0]       ent_priv,
  input  logic [ENTRIES-1:0][UNIT_W-1:0]       ent_unit,
  input  logic [ID_W-1:0]                      key_ident,
  input  logic [DEV_W-1:0]                     key_dev,
  input  logic [PRIV_W-1:0]                    key_priv,
  output logic                                 hit,
  output logic [ENTRIES-1:0]                   grant,
  output logic [UNIT_W-1:0]                    unit
);

  logic [ENTRIES-1:0] cand;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign cand[g] = ent_valid[g]
                   && (ent_ident[g] == key_ident)
                   && (ent_dev[g]   == key_dev)
                   && (ent_priv[g]  == key_priv);
  end

  // Isolate the lowest set candidate: lowest index has priority.
  assign grant = cand & (~cand + ENTRIES'(1));
  assign hit   = |cand;

  always_comb begin
    unit = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      unit = unit | (grant[i] ? ent_unit[i] : '0);
    end
  end

endmodule

// File: rtl/ifx_result.sv
module ifx_result
  import ifx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [1:0]             req_variant,
  input  logic                   hit,
  input  logic [UNIT_W-1:0]      hit_unit,
  input  logic [XLEN-UNIT_W-1:0] req_data,
  output logic                   done,
  output logic [XLEN-1:0]        rd
);

  localparam int HI_W = XLEN - UNIT_W;

  logic [XLEN-1:0] rd_d, rd_q;
  logic            done_d, done_q;

  always_comb begin
    if (hit) rd_d = {req_data, hit_unit};
    else     rd_d = {{HI_W{1'b0}}, miss_unit(req_variant)};
    done_d = req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= done_d;
      if (req_valid) rd_q <= rd_d;
    end
  end

  assign done = done_q;
  assign rd   = rd_q;

endmodule

// File: rtl/ifid_xlate.sv
module ifid_xlate
  import ifx_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ENTRIES = 8,
  localparam int ID_W   = XLEN - DEV_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tbl_clear,
  input  logic                   tbl_wr_en,
  input  logic [IDX_W-1:0]       tbl_wr_idx,
  input  logic [ID_W-1:0]        tbl_wr_ident,
  input  logic [DEV_W-1:0]       tbl_wr_dev,
  input  logic [PRIV_W-1:0]      tbl_wr_priv,
  input  logic [UNIT_W-1:0]      tbl_wr_unit,
  input  logic                   req_valid,
  input  logic [1:0]             req_variant,
  input  logic [PRIV_W-1:0]      req_priv,
  input  logic [XLEN-1:0]        req_rs1,
  input  logic [XLEN-UNIT_W-1:0] req_data,
  output logic                   rsp_done,
  output logic [XLEN-1:0]        rsp_rd
);

  logic [ENTRIES-1:0]             entry_valid;
  logic [ENTRIES-1:0][ID_W-1:0]   ent_ident;
  logic [ENTRIES-1:0][DEV_W-1:0]  ent_dev;
  logic [ENTRIES-1:0][PRIV_W-1:0] ent_priv;
  logic [ENTRIES-1:0][UNIT_W-1:0] ent_unit;
  logic [ENTRIES-1:0]             grant;
  logic                           hit;
  logic [UNIT_W-1:0]              hit_unit;

  ifx_table #(
    .ENTRIES(ENTRIES), .ID_W(ID_W), .IDX_W(IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tbl_clear),
    .wr_en    (tbl_wr_en),
    .wr_idx   (tbl_wr_idx),
    .wr_ident (tbl_wr_ident),
    .wr_dev   (tbl_wr_dev),
    .wr_priv  (tbl_wr_priv),
    .wr_unit  (tbl_wr_unit),
    .ent_valid(entry_valid),
    .ent_ident(ent_ident),
    .ent_dev  (ent_dev),
    .ent_priv (ent_priv),
    .ent_unit (ent_unit)
  );

  ifx_match #(
    .ENTRIES(ENTRIES), .ID_W(ID_W)
  ) u_match (
    .ent_valid(entry_valid),
    .ent_ident(ent_ident),
    .ent_dev  (ent_dev),
    .ent_priv (ent_priv),
    .ent_unit (ent_unit),
    .key_ident(req_rs1[XLEN-1:DEV_W]),
    .key_dev  (req_rs1[DEV_W-1:0]),
    .key_priv (req_priv),
    .hit      (hit),
    .grant    (grant),
    .unit     (hit_unit)
  );

  ifx_result #(
    .XLEN(XLEN)
  ) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_variant(req_variant),
    .hit        (hit),
    .hit_unit   (hit_unit),
    .req_data   (req_data),
    .done       (rsp_done),
    .rd         (rsp_rd)
  );

endmodule

// File: rtl/ifx_checker.sv
module ifx_checker
  import ifx_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tbl_clear,
  input logic                   tbl_wr_en,
  input logic [IDX_W-1:0]       tbl_wr_idx,
  input logic                   req_valid,
  input logic [1:0]             req_variant,
  input logic [XLEN-UNIT_W-1:0] req_data,
  input logic                   rsp_done,
  input logic [XLEN-1:0]        rsp_rd,
  input logic [ENTRIES-1:0]     entry_valid,
  input logic [ENTRIES-1:0]     grant
);

  // Tracks whether no entry has been written since reset or the last clear.
  logic empty_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          empty_q <= 1'b1;
    else if (tbl_clear)                                  empty_q <= 1'b1;
    else if (tbl_wr_en && (int'(tbl_wr_idx) < ENTRIES)) empty_q <= 1'b0;
  end

  a_r9_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_done);

  a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_done);

  a_r9_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_rd));

  a_r4_empty_table_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && empty_q) |=>
      (rsp_rd == {{(XLEN-UNIT_W){1'b0}}, miss_unit($past(req_variant))}));

  a_r2_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((rsp_rd[XLEN-1:UNIT_W] == '0) ||
                   (rsp_rd[XLEN-1:UNIT_W] == $past(req_data))));

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clear |=> (entry_valid == '0));

  a_r7_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_wr_en && !tbl_clear && (int'(tbl_wr_idx) < ENTRIES)) |=>
      entry_valid[$past(tbl_wr_idx)]);

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~entry_valid) == '0));

endmodule

bind ifid_xlate ifx_checker #(
  .XLEN(XLEN), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
) u_ifx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tbl_clear  (tbl_clear),
  .tbl_wr_en  (tbl_wr_en),
  .tbl_wr_idx (tbl_wr_idx),
  .req_valid  (req_valid),
  .req_variant(req_variant),
  .req_data   (req_data),
  .rsp_done   (rsp_done),
  .rsp_rd     (rsp_rd),
  .entry_valid(entry_valid),
  .grant      (grant)
);

// File: tb/test_ifid_xlate.sv
`timescale 1ns/1ps
module test_ifid_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_clear = 1'b0;
  logic        tbl_wr_en = 1'b0;
  logic [2:0]  tbl_wr_idx = '0;
  logic [19:0] tbl_wr_ident = '0;
  logic [11:0] tbl_wr_dev = '0;
  logic [3:0]  tbl_wr_priv = '0;
  logic [11:0] tbl_wr_unit = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_variant = '0;
  logic [3:0]  req_priv = '0;
  logic [31:0] req_rs1 = '0;
  logic [19:0] req_data = '0;
  logic        rsp_done;
  logic [31:0] rsp_rd;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench-side table model.
  bit          m_valid [8];
  logic [19:0] m_id    [8];
  logic [11:0] m_dev   [8];
  logic [3:0]  m_priv  [8];
  logic [11:0] m_unit  [8];

  always #2.5 clk = ~clk;

  ifid_xlate i_ifid_xlate (
    .clk(clk), .rst_n(rst_n), .tbl_clear(tbl_clear), .tbl_wr_en(tbl_wr_en),
    .tbl_wr_idx(tbl_wr_idx), .tbl_wr_ident(tbl_wr_ident), .tbl_wr_dev(tbl_wr_dev),
    .tbl_wr_priv(tbl_wr_priv), .tbl_wr_unit(tbl_wr_unit), .req_valid(req_valid),
    .req_variant(req_variant), .req_priv(req_priv), .req_rs1(req_rs1),
    .req_data(req_data), .rsp_done(rsp_done), .rsp_rd(rsp_rd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] v, input logic [3:0] p,
                                        input logic [31:0] rs1, input logic [19:0] d);
    for (int i = 0; i < 8; i++)
      if (m_valid[i] && m_id[i] == rs1[31:12] && m_dev[i] == rs1[11:0] && m_priv[i] == p)
        return {d, m_unit[i]};
    return (v == 2'd1) ? 32'd1 : (v == 2'd2) ? 32'd2 : 32'd0;
  endfunction

  task automatic wr(input int idx, input logic [19:0] id, input logic [11:0] dev,
                    input logic [3:0] p, input logic [11:0] u);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = 3'(idx); tbl_wr_ident = id;
    tbl_wr_dev = dev; tbl_wr_priv = p; tbl_wr_unit = u;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    m_valid[idx] = 1'b1; m_id[idx] = id; m_dev[idx] = dev;
    m_priv[idx] = p; m_unit[idx] = u;
  endtask

  // Issue one request; result sampled a half cycle after the capturing edge.
  task automatic req(input logic [1:0] v, input logic [3:0] p, input logic [31:0] rs1,
                     input logic [19:0] d, output logic [31:0] got);
    @(negedge clk);
    req_valid = 1'b1; req_variant = v; req_priv = p; req_rs1 = rs1; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 done pulse", {31'd0, rsp_done}, 32'd1);
    got = rsp_rd;
  endtask

  task automatic req_chk(input string tag, input logic [1:0] v, input logic [3:0] p,
                         input logic [31:0] rs1, input logic [19:0] d, input logic [31:0] exp);
    logic [31:0] got;
    req(v, p, rs1, d, got);
    check(tag, got, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic [19:0] ids [5] = '{20'hABCDE, 20'h12345, 20'hFFFFF, 20'h00000, 20'hABCDF};
    logic [11:0] devs [3] = '{12'h000, 12'h001, 12'hFFF};
    logic [3:0]  privs [5] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0000};

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 done after reset", {31'd0, rsp_done}, 32'd0);
    check("R10 result after reset", rsp_rd, 32'd0);
    rst_n = 1'b1;
    // R10: empty table misses for every variant (R4 codes)
    for (int v = 0; v < 4; v++)
      req_chk("R10 empty table miss", 2'(v), 4'b0001, 32'hABCDE000, 20'hFFFFF,
              (v == 1) ? 32'd1 : (v == 2) ? 32'd2 : 32'd0);

    wr(0, 20'hABCDE, 12'h000, 4'b0001, 12'h020);
    wr(1, 20'hABCDE, 12'h001, 4'b0010, 12'h021);
    wr(2, 20'hABCDE, 12'h000, 4'b0010, 12'h022);
    wr(3, 20'h12345, 12'h000, 4'b0001, 12'h033);
    wr(4, 20'h12345, 12'h000, 4'b0001, 12'h044);
    wr(5, 20'h12345, 12'h000, 4'b1000, 12'h055);
    wr(6, 20'hFFFFF, 12'hFFF, 4'b0100, 12'hFFF);

    // Directed checks with hand-derived values
    req_chk("R1 default device field", 2'd0, 4'b0001, 32'hABCDE000, 20'h00000, 32'h00000020);
    req_chk("R1 device 1 field", 2'd0, 4'b0010, 32'hABCDE001, 20'h00000, 32'h00000021);
    req_chk("R2 payload packing", 2'd0, 4'b0001, 32'hABCDE000, 20'hFFFFF, 32'hFFFFF020);
    req_chk("R3 privilege mismatch", 2'd1, 4'b0100, 32'hABCDE000, 20'h12345, 32'h00000001);
    req_chk("R3 device mismatch", 2'd2, 4'b0001, 32'hABCDE001, 20'h12345, 32'h00000002);
    req_chk("R5 user unit", 2'd0, 4'b0001, 32'hABCDE000, 20'h00001, 32'h00001020);
    req_chk("R5 supervisor unit", 2'd0, 4'b0010, 32'hABCDE000, 20'h00001, 32'h00001022);
    req_chk("R6 lowest index wins", 2'd0, 4'b0001, 32'h12345000, 20'h00000, 32'h00000033);
    req_chk("R4 reserved variant", 2'd3, 4'b0001, 32'h00000000, 20'hFFFFF, 32'h00000000);

    // Near-exhaustive sweep, expected values from the bench model
    foreach (ids[a]) foreach (devs[b]) foreach (privs[c])
      for (int v = 0; v < 4; v++) begin
        logic [31:0] rs1;
        logic [19:0] d;
        logic [31:0] exp;
        rs1 = {ids[a], devs[b]};
        d   = ids[a] ^ {8'h5A, devs[b]} ^ 20'(v * 20'h11111);
        exp = model(2'(v), privs[c], rs1, d);
        req(2'(v), privs[c], rs1, d, got);
        check((exp[31:12] != 0 || exp[11:0] > 12'd2) ? "R2 sweep hit" : "R4 sweep miss/hit",
              got, exp);
      end

    // R9: done falls and result holds one cycle after a request
    req_chk("R9 setup", 2'd0, 4'b0100, 32'hFFFFFFFF, 20'hABCDE, 32'hABCDEFFF);
    @(negedge clk);
    check("R9 done low when idle", {31'd0, rsp_done}, 32'd0);
    check("R9 result holds", rsp_rd, 32'hABCDEFFF);
    // R9: back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_variant = 2'd2; req_priv = 4'b1000; req_rs1 = 32'h12345000; req_data = 20'h00007;
    @(negedge clk);
    check("R9 back-to-back first", rsp_rd, 32'h00007055);
    req_variant = 2'd2; req_priv = 4'b1000; req_rs1 = 32'h99999000; req_data = 20'h00007;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 back-to-back second", rsp_rd, 32'h00000002);
    check("R9 done stays high", {31'd0, rsp_done}, 32'd1);

    // R8: clear with a simultaneous write to entry 7; clear wins
    @(negedge clk);
    tbl_clear = 1'b1; tbl_wr_en = 1'b1; tbl_wr_idx = 3'd7;
    tbl_wr_ident = 20'h77777; tbl_wr_dev = 12'h007; tbl_wr_priv = 4'b0001; tbl_wr_unit = 12'h777;
    @(negedge clk);
    tbl_clear = 1'b0; tbl_wr_en = 1'b0;
    for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
    req_chk("R8 clear beats write", 2'd1, 4'b0001, 32'h77777007, 20'h1, 32'h00000001);
    req_chk("R8 earlier entry gone", 2'd0, 4'b0001, 32'hABCDE000, 20'h1, 32'h00000000);

    // R7: write then look up
    wr(7, 20'h77777, 12'h007, 4'b0001, 12'h777);
    req_chk("R7 new entry visible", 2'd1, 4'b0001, 32'h77777007, 20'h00042, 32'h00042777);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule